// File: doc/BRIEF.md
# Credit-Gated Receive Link Controller

This block sits on the sending side of a receive channel whose flow is governed by credits. An internal packet source hands it beats, each marked with start and end of packet. The block forwards those beats to an application, and it only lets a new packet begin while it holds at least one credit. The application grants credits as single-cycle pulses on one wire. Packet data and sideband contents pass through untouched.

The link begins in a stopped state. When the source offers the first beat of a packet, the block raises its activation request and holds it. It enters the active state once the application acknowledges. Credit grants are counted only while the link is active. A grant that arrives in any other state adds nothing and raises a one-cycle protocol error flag.

When the application asks the link to wind down, any packet already in progress runs to its last beat. The block then hands every unused credit back, one pulse per cycle, and falls back to the stopped state.

Top module: `rx_credit_link_ctrl`

## Requirements
- R1: While rst_ni is low the link is stopped and link_req_o, credit_rtn_o, pkt_ready_o, out_valid_o and proto_err_o are all 0.
- R2: In the stopped state, a beat with pkt_valid_i=1 and pkt_sop_i=1 while deact_hint_i=0 moves the link to the requesting state on the next edge. There link_req_o=1, and pkt_ready_o and out_valid_o stay 0 until link_ack_i is seen.
- R3: link_ack_i=1 in the requesting state moves the link to the active state on the next edge. link_req_o stays 1 in both the requesting and the active state.
- R4: A new packet is forwarded (pkt_ready_o=1, out_valid_o=pkt_valid_i) only in the active state with a credit count of at least 1. The beat that carries pkt_sop_i and is accepted uses up one credit. With no credit left, out_valid_o and pkt_ready_o stay 0 at a packet boundary.
- R5: Each cycle in the active state with credit_gnt_i=1 adds one credit, and that credit can be used from the next cycle on.
- R6: The credit count saturates at MAX_CREDITS. Further grants while full are lost.
- R7: Once a packet has started, its later beats are forwarded (pkt_ready_o=1) in any state until the beat carrying pkt_eop_i is accepted. No return pulse is issued while such a packet is open.
- R8: deact_hint_i=1 in the active state moves the link to the returning state, and link_req_o is 0 from then on. In the returning state no new packet starts. The link goes back to stopped when the count is zero and no packet is open, and a later packet start raises link_req_o again.
- R9: credit_gnt_i=1 outside the active state adds no credit and drives proto_err_o to 1 for exactly the following cycle.
- R10: In the returning state with no packet open, credit_rtn_o is 1 in each cycle while credits remain, and each pulse removes one credit. The number of pulses equals the credits held when the hint arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pkt_valid_i | input | 1 | Source beat valid |
| pkt_sop_i | input | 1 | Beat is first of a packet |
| pkt_eop_i | input | 1 | Beat is last of a packet |
| pkt_data_i | input | DATA_W | Beat payload |
| pkt_ready_o | output | 1 | Source beat accepted when valid |
| out_valid_o | output | 1 | Beat valid toward the application |
| out_sop_o | output | 1 | Start marker toward the application |
| out_eop_o | output | 1 | End marker toward the application |
| out_data_o | output | DATA_W | Payload toward the application |
| credit_gnt_i | input | 1 | One credit granted per high cycle |
| credit_rtn_o | output | 1 | One credit handed back per high cycle |
| link_req_o | output | 1 | Activation request |
| link_ack_i | input | 1 | Activation acknowledge |
| deact_hint_i | input | 1 | Request to wind the link down |
| proto_err_o | output | 1 | Grant seen outside the active state |

## Verification
The hardest case to reach is a deactivation hint that lands inside a multi-beat packet, with credits still held. Returns must wait for the end beat, and the block must not start anything new after it. The bench starts a three-beat packet with two credits granted and raises the hint on the middle beat. It checks that returns are held back until the end beat is accepted. It then injects a grant during the return to confirm that the grant is neither counted nor left unflagged. A sweep over every grant count up to past saturation, crossed with every packet count, checks the returned total arithmetically.

// File: rtl/rx_link_pkg.sv
package rx_link_pkg;
  typedef enum logic [1:0] {
    LS_STOP   = 2'd0,
    LS_REQ    = 2'd1,
    LS_ACTIVE = 2'd2,
    LS_RETURN = 2'd3
  } link_state_e;
endpackage

// File: rtl/rx_link_fsm.sv
module rx_link_fsm
  import rx_link_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pkt_want_i,
  input  logic        ack_i,
  input  logic        hint_i,
  input  logic        drained_i,
  output link_state_e state_o
);
  link_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LS_STOP:   if (pkt_want_i && !hint_i) state_d = LS_REQ;
      LS_REQ:    if (ack_i) state_d = LS_ACTIVE;
      LS_ACTIVE: if (hint_i) state_d = LS_RETURN;
      LS_RETURN: if (drained_i) state_d = LS_STOP;
      default:   state_d = LS_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LS_STOP;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/rx_credit_cnt.sv
module rx_credit_cnt #(
  parameter int MAX_CREDITS = 64,
  localparam int CNT_W = $clog2(MAX_CREDITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_i,
  input  logic             take_i,
  input  logic             ret_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             empty_o
);
  localparam logic [CNT_W-1:0] MaxC = CNT_W'(MAX_CREDITS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec;

  // take and ret never coincide: take only when active, ret only when returning
  assign dec = take_i | ret_i;

  always_comb begin
    cnt_d = cnt_q;
    unique case ({add_i, dec})
      2'b10:   if (cnt_q != MaxC) cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o   = cnt_q;
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/rx_pkt_gate.sv
module rx_pkt_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sop_i,
  input  logic eop_i,
  input  logic can_start_i,
  output logic ready_o,
  output logic valid_o,
  output logic start_o,
  output logic in_pkt_o
);
  logic in_pkt_q;
  logic accept;

  assign ready_o  = in_pkt_q | (sop_i & can_start_i);
  assign valid_o  = valid_i & ready_o;
  assign accept   = valid_o;
  assign start_o  = accept & !in_pkt_q;
  assign in_pkt_o = in_pkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     in_pkt_q <= 1'b0;
    else if (accept) in_pkt_q <= !eop_i;
  end
endmodule

// File: rtl/rx_credit_link_ctrl.sv
module rx_credit_link_ctrl
  import rx_link_pkg::*;
#(
  parameter int MAX_CREDITS = 64,
  parameter int DATA_W      = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_valid_i,
  input  logic              pkt_sop_i,
  input  logic              pkt_eop_i,
  input  logic [DATA_W-1:0] pkt_data_i,
  output logic              pkt_ready_o,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              credit_gnt_i,
  output logic              credit_rtn_o,
  output logic              link_req_o,
  input  logic              link_ack_i,
  input  logic              deact_hint_i,
  output logic              proto_err_o
);
  localparam int CNT_W = $clog2(MAX_CREDITS + 1);

  link_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic             empty, in_pkt, start, active, returning, err_q;

  assign active    = (state == LS_ACTIVE);
  assign returning = (state == LS_RETURN);

  rx_link_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pkt_want_i (pkt_valid_i & pkt_sop_i),
    .ack_i      (link_ack_i),
    .hint_i     (deact_hint_i),
    .drained_i  (empty & !in_pkt),
    .state_o    (state)
  );

  rx_pkt_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (pkt_valid_i),
    .sop_i       (pkt_sop_i),
    .eop_i       (pkt_eop_i),
    .can_start_i (active & !empty),
    .ready_o     (pkt_ready_o),
    .valid_o     (out_valid_o),
    .start_o     (start),
    .in_pkt_o    (in_pkt)
  );

  rx_credit_cnt #(.MAX_CREDITS(MAX_CREDITS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .add_i   (credit_gnt_i & active),
    .take_i  (start),
    .ret_i   (credit_rtn_o),
    .cnt_o   (cnt),
    .empty_o (empty)
  );

  assign credit_rtn_o = returning & !empty & !in_pkt;
  assign link_req_o   = (state == LS_REQ) | active;
  assign out_sop_o    = pkt_sop_i;
  assign out_eop_o    = pkt_eop_i;
  assign out_data_o   = pkt_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= credit_gnt_i & !active;
  end
  assign proto_err_o = err_q;
endmodule

// File: rtl/rx_credit_link_chk.sv
module rx_credit_link_chk
  import rx_link_pkg::*;
#(
  parameter int MAX_CREDITS = 64,
  localparam int CNT_W = $clog2(MAX_CREDITS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input link_state_e      state_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             in_pkt_i,
  input logic             gnt_i,
  input logic             rtn_i,
  input logic             req_i,
  input logic             out_valid_i,
  input logic             out_sop_i,
  input logic             err_i
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(MAX_CREDITS)); // R6
  AST_START_HAS_CREDIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && out_sop_i && !in_pkt_i) |-> (cnt_i != '0)); // R4
  AST_REQ_HELD_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == LS_ACTIVE) |-> req_i); // R3
  AST_RTN_DECREMENTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtn_i |=> (cnt_i == $past(cnt_i) - 1'b1)); // R10
  AST_IDLE_GRANT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i && state_i != LS_ACTIVE) |=> err_i); // R9
  AST_STOP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == LS_STOP) |-> (cnt_i == '0)); // R8
  AST_NO_RTN_OPEN_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pkt_i |-> !rtn_i); // R7
endmodule

bind rx_credit_link_ctrl rx_credit_link_chk #(.MAX_CREDITS(MAX_CREDITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_i     (state),
  .cnt_i       (cnt),
  .in_pkt_i    (in_pkt),
  .gnt_i       (credit_gnt_i),
  .rtn_i       (credit_rtn_o),
  .req_i       (link_req_o),
  .out_valid_i (out_valid_o),
  .out_sop_i   (out_sop_o),
  .err_i       (proto_err_o)
);

// File: tb/tb_rx_credit_link_ctrl.sv
module tb_rx_credit_link_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC       = 4;
  localparam int DW         = 8;

  logic clk = 0, rst_n = 0;
  logic pkt_valid = 0, pkt_sop = 0, pkt_eop = 0;
  logic [DW-1:0] pkt_data = '0;
  logic pkt_ready, out_valid, out_sop, out_eop;
  logic [DW-1:0] out_data;
  logic gnt = 0, rtn, req, ack = 0, hint = 0, err;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_credit_link_ctrl #(.MAX_CREDITS(MAXC), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pkt_valid_i(pkt_valid), .pkt_sop_i(pkt_sop), .pkt_eop_i(pkt_eop),
    .pkt_data_i(pkt_data), .pkt_ready_o(pkt_ready),
    .out_valid_o(out_valid), .out_sop_o(out_sop), .out_eop_o(out_eop),
    .out_data_o(out_data),
    .credit_gnt_i(gnt), .credit_rtn_o(rtn), .link_req_o(req),
    .link_ack_i(ack), .deact_hint_i(hint), .proto_err_o(err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 0; pkt_valid = 0; pkt_sop = 0; pkt_eop = 0;
    gnt = 0; ack = 0; hint = 0;
    repeat (2) tick();
    rst_n = 1;
  endtask

  // from stopped to active; returns with link active, sampled after the edge
  task automatic activate();
    pkt_valid = 1; pkt_sop = 1; pkt_eop = 1;
    tick();
    chk(req == 1, "R2 req", req, 1);
    chk(pkt_ready == 0, "R2 ready", pkt_ready, 0);
    ack = 1;
    tick();
    chk(req == 1, "R3 req", req, 1);
    pkt_valid = 0;
  endtask

  task automatic run(input int k, input int n);
    int held, used, rcnt;
    do_reset();
    activate();
    pkt_valid = 1; #1;
    chk(out_valid == 0, "R4 no credit", out_valid, 0);
    pkt_valid = 0;
    for (int i = 0; i < k; i++) begin gnt = 1; tick(); end
    gnt = 0;
    held = (k < MAXC) ? k : MAXC;
    used = 0;
    for (int j = 0; j < n; j++) begin
      pkt_valid = 1; pkt_sop = 1; pkt_eop = 1; pkt_data = DW'(j + 3); #1;
      chk(out_valid == (j < held), "R5 start gated", out_valid, int'(j < held));
      if (out_valid) chk(out_data == DW'(j + 3), "R4 data", out_data, j + 3);
      if (j < held) used++;
      tick();
    end
    pkt_valid = 0; hint = 1;
    tick();
    chk(req == 0, "R8 req drop", req, 0);
    hint = 0;
    rcnt = 0;
    for (int c = 0; c < MAXC + 4; c++) begin
      if (rtn) rcnt++;
      tick();
    end
    chk(rcnt == held - used, (k > MAXC) ? "R6 saturated return" : "R10 return count",
        rcnt, held - used);
    chk(req == 0, "R8 stopped", req, 0);
  endtask

  initial begin
    int rcnt;
    // R1
    rst_n = 0;
    #(CLK_PERIOD * 2 + 1);
    chk(req == 0, "R1 req", req, 0);
    chk(rtn == 0, "R1 rtn", rtn, 0);
    chk(pkt_ready == 0, "R1 ready", pkt_ready, 0);
    chk(out_valid == 0, "R1 valid", out_valid, 0);
    chk(err == 0, "R1 err", err, 0);

    // R9: grant while stopped
    do_reset();
    tick();
    gnt = 1; tick(); gnt = 0;
    chk(err == 1, "R9 err set", err, 1);
    tick();
    chk(err == 0, "R9 err one cycle", err, 0);
    activate();
    hint = 1; tick(); hint = 0;
    rcnt = 0;
    for (int c = 0; c < 6; c++) begin if (rtn) rcnt++; tick(); end
    chk(rcnt == 0, "R9 no credit added", rcnt, 0);

    // sweep grants x packets
    for (int k = 0; k <= MAXC + 2; k++)
      for (int n = 0; n <= MAXC + 1; n++)
        run(k, n);

    // R7: hint inside a multi-beat packet
    do_reset();
    activate();
    gnt = 1; tick(); tick(); gnt = 0;
    pkt_valid = 1; pkt_sop = 1; pkt_eop = 0; #1;
    chk(out_valid == 1, "R4 start", out_valid, 1);
    tick();
    pkt_sop = 0; hint = 1; #1;
    chk(pkt_ready == 1, "R7 mid beat", pkt_ready, 1);
    tick();
    hint = 0;
    chk(rtn == 0, "R7 held return", rtn, 0);
    chk(pkt_ready == 1, "R7 continue", pkt_ready, 1);
    pkt_eop = 1;
    tick();
    pkt_valid = 0; pkt_eop = 0;
    chk(rtn == 1, "R10 return after eop", rtn, 1);
    pkt_valid = 1; pkt_sop = 1; pkt_eop = 1; #1;
    chk(pkt_ready == 0, "R8 no new start", pkt_ready, 0);
    chk(out_valid == 0, "R8 no new valid", out_valid, 0);
    pkt_valid = 0; pkt_sop = 0; pkt_eop = 0;
    gnt = 1;
    tick();
    gnt = 0;
    chk(err == 1, "R9 grant in return", err, 1);
    chk(rtn == 0, "R9 grant ignored", rtn, 0);
    tick();
    pkt_valid = 1; pkt_sop = 1; pkt_eop = 1;
    tick();
    chk(req == 1, "R8 re-request", req, 1);
    pkt_valid = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule